// File: doc/BRIEF.md
# Vectored Interrupt Controller with Register Port

This block gathers a parameterised number of interrupt lines (one to thirty-two) into one request for a processor. Each line is fixed at elaboration time as rising-edge or level capture by a kind mask. A captured event sets a status bit. The status bit stays set until software clears it through the acknowledge register. A per-line enable masks the status into a pending set. A vector register reports the lowest-numbered pending line, so the interrupt entry code can branch without scanning bits.

Software uses a single-cycle register port. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the present state. Enables can be written whole, or changed atomically through a set-only register and a clear-only register. Those two registers leave the untouched bits as they were, so no read-modify-write is needed. A control register holds two gates: a run bit and a one-way hardware-request bit. Both gates must be on before the request output can assert.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, every readable register reads zero except the vector register (byte offset 0x18), which reads all ones, and `irq_o` is low.
- R2: A write to the enable register (offset 0x08) loads its low NUM_SRC bits. A read returns them, and bits at or above NUM_SRC always read zero.
- R3: A write to offset 0x10 sets the enable bits named by the mask. A write to offset 0x14 clears them. All other enable bits keep their value.
- R4: A line whose KIND_MASK bit is 1 sets its status bit (offset 0x00) once per low-to-high transition. A line held high does not set it again after it has been acknowledged.
- R5: A line whose KIND_MASK bit is 0 sets its status bit on every cycle it is high. It therefore reappears right after an acknowledge while it stays high.
- R6: A write to offset 0x0C clears the status bits named by the mask. A capture event in the same cycle wins, and that bit stays set.
- R7: The pending register (offset 0x04) reads as status AND enable.
- R8: The vector register reads the index of the lowest-numbered pending bit, or all ones when nothing is pending.
- R9: In the control register (offset 0x1C), bit 0 is the run bit and bit 1 the hardware-request bit. `irq_o` is high exactly when both are set and at least one bit is pending.
- R10: Once the hardware-request bit is written to 1, it cannot be cleared by software. The run bit remains freely writable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | NUM_SRC | Interrupt lines |
| reg_addr | input | 5 | Byte address of the register; bits [4:2] select it |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives in the same clock cycle as a fresh capture event on the same line. The acknowledge must lose in that case. The bench creates the collision by raising an edge-type line and issuing the acknowledge write at the same falling edge, so both are sampled together. It also holds a level line high across an acknowledge, so the level capture re-sets the bit as the acknowledge clears it. Around these cases, the bench sweeps every status pattern of an eight-line configuration with varied enables, checking the pending, vector and request outputs arithmetically.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int DATA_W = 32;
   localparam int SEL_W  = 3;

   typedef enum logic [SEL_W-1:0] {
      SEL_STAT  = 3'd0,
      SEL_PEND  = 3'd1,
      SEL_EN    = 3'd2,
      SEL_ACK   = 3'd3,
      SEL_SETEN = 3'd4,
      SEL_CLREN = 3'd5,
      SEL_VEC   = 3'd6,
      SEL_CTRL  = 3'd7
   } reg_sel_e;
endpackage

// File: rtl/irqc_capture.sv
module irqc_capture #(
   parameter int          NUM_SRC   = 32,
   parameter logic [31:0] KIND_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src,
   input  logic [NUM_SRC-1:0] ack_mask,
   output logic [NUM_SRC-1:0] stat
);
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_line
      logic hit;
      if (KIND_MASK[i]) begin : g_edge
         logic src_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) src_q <= 1'b0;
            else        src_q <= src[i];
         end
         assign hit = src[i] & ~src_q;
      end else begin : g_level
         assign hit = src[i];
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           stat[i] <= 1'b0;
         else if (hit)         stat[i] <= 1'b1;
         else if (ack_mask[i]) stat[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
   parameter int NUM_SRC = 32,
   parameter int VEC_W   = 32
) (
   input  logic [NUM_SRC-1:0] pend,
   output logic [VEC_W-1:0]   vec
);
   always_comb begin
      vec = '1;
      for (int i = NUM_SRC - 1; i >= 0; i--) begin
         if (pend[i]) vec = VEC_W'(i);
      end
   end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
   import irqc_pkg::*;
#(
   parameter int          NUM_SRC   = 32,
   parameter logic [31:0] KIND_MASK = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_i,
   input  logic [4:0]         reg_addr,
   input  logic               reg_wr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   output logic               irq_o
);
   if (NUM_SRC < 1 || NUM_SRC > DATA_W) begin : g_bad_num
      $error("irq_ctrl: NUM_SRC must lie in 1..32");
   end
   if ((KIND_MASK >> NUM_SRC) != 0) begin : g_bad_kind
      $error("irq_ctrl: KIND_MASK has bits above NUM_SRC");
   end

   reg_sel_e           sel;
   logic [NUM_SRC-1:0] wmask;
   logic [NUM_SRC-1:0] ack_mask;
   logic [NUM_SRC-1:0] stat;
   logic [NUM_SRC-1:0] en;
   logic [NUM_SRC-1:0] pend;
   logic [DATA_W-1:0]  vec;
   logic               me;
   logic               hie;

   assign sel      = reg_sel_e'(reg_addr[4:2]);
   assign wmask    = reg_wdata[NUM_SRC-1:0];
   assign ack_mask = (reg_wr && sel == SEL_ACK) ? wmask : '0;

   irqc_capture #(.NUM_SRC(NUM_SRC), .KIND_MASK(KIND_MASK)) cap_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .src      (src_i),
      .ack_mask (ack_mask),
      .stat     (stat)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en <= '0;
      end else if (reg_wr) begin
         case (sel)
            SEL_EN:    en <= wmask;
            SEL_SETEN: en <= en | wmask;
            SEL_CLREN: en <= en & ~wmask;
            default:   en <= en;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         me  <= 1'b0;
         hie <= 1'b0;
      end else if (reg_wr && sel == SEL_CTRL) begin
         me  <= reg_wdata[0];
         hie <= hie | reg_wdata[1];
      end
   end

   assign pend = stat & en;

   irqc_prio #(.NUM_SRC(NUM_SRC), .VEC_W(DATA_W)) prio_i (
      .pend (pend),
      .vec  (vec)
   );

   assign irq_o = (|pend) & me & hie;

   always_comb begin
      case (sel)
         SEL_STAT: reg_rdata = DATA_W'(stat);
         SEL_PEND: reg_rdata = DATA_W'(pend);
         SEL_EN:   reg_rdata = DATA_W'(en);
         SEL_VEC:  reg_rdata = vec;
         SEL_CTRL: reg_rdata = {30'd0, hie, me};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
   parameter int          NUM_SRC   = 32,
   parameter logic [31:0] KIND_MASK = '0
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_i,
   input logic [4:0]         reg_addr,
   input logic               reg_wr,
   input logic [31:0]        reg_wdata,
   input logic [NUM_SRC-1:0] stat,
   input logic [NUM_SRC-1:0] en,
   input logic [NUM_SRC-1:0] pend,
   input logic [31:0]        vec,
   input logic               hie
);
   localparam logic [NUM_SRC-1:0] EDGE_M = KIND_MASK[NUM_SRC-1:0];

   logic [31:0] p32;
   assign p32 = 32'(pend);

   // R3: set-only register leaves the masked bits enabled
   a_r3_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && reg_addr[4:2] == 3'd4) |->
         ((en & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

   // R3: clear-only register leaves the masked bits disabled
   a_r3_clr_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $past(reg_wr && reg_addr[4:2] == 3'd5) |->
         ((en & $past(reg_wdata[NUM_SRC-1:0])) == '0));

   // R4: an edge line only rises in status when its input was high
   a_r4_edge_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((stat & ~$past(stat) & EDGE_M & ~$past(src_i)) == '0));

   // R5: a level line sampled high is reflected in status next cycle
   a_r5_level_set: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> ((~stat & ~EDGE_M & $past(src_i)) == '0));

   // R6: acknowledged bits with a quiet input are cleared
   a_r6_ack_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n && reg_wr && reg_addr[4:2] == 3'd3) |->
         ((stat & $past(reg_wdata[NUM_SRC-1:0]) & ~$past(src_i)) == '0));

   // R8: the vector names a pending bit with none pending below it
   a_r8_vec_lowest: assert property (@(posedge clk) disable iff (!rst_n)
      (vec != '1) |-> (p32[vec[4:0]] && ((p32 & ((32'd1 << vec[4:0]) - 32'd1)) == 0)));

   a_r8_vec_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (vec == '1) |-> (pend == '0));

   // R10: the hardware-request bit never falls outside reset
   a_r10_hie_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(hie) |-> hie);
endmodule

bind irq_ctrl irq_ctrl_chk #(.NUM_SRC(NUM_SRC), .KIND_MASK(KIND_MASK)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_i     (src_i),
   .reg_addr  (reg_addr),
   .reg_wr    (reg_wr),
   .reg_wdata (reg_wdata),
   .stat      (stat),
   .en        (en),
   .pend      (pend),
   .vec       (vec),
   .hie       (hie)
);

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
   localparam int N = 8;
   localparam logic [31:0] KIND = 32'h0000_00F0;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [N-1:0]  src_i = '0;
   logic [4:0]    reg_addr = '0;
   logic          reg_wr = 1'b0;
   logic [31:0]   reg_wdata = '0;
   logic [31:0]   reg_rdata;
   logic          irq_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   always #4 clk = ~clk;

   irq_ctrl #(.NUM_SRC(N), .KIND_MASK(KIND)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o)
   );

   localparam logic [4:0] A_STAT = 5'h00, A_PEND = 5'h04, A_EN = 5'h08, A_ACK = 5'h0C,
                          A_SET = 5'h10, A_CLR = 5'h14, A_VEC = 5'h18, A_CTRL = 5'h1C;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b1; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [N-1:0] p);
      @(negedge clk); src_i = p;
      @(negedge clk); src_i = '0;
   endtask

   function automatic logic [31:0] lowest(input logic [N-1:0] p);
      lowest = '1;
      for (int i = N - 1; i >= 0; i--) if (p[i]) lowest = 32'(i);
   endfunction

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 0; a < 8; a++) begin
         rd(5'(a * 4), d);
         check("R1 reset read", d, (a == 6) ? 32'hFFFF_FFFF : 32'h0);
      end
      check("R1 irq low", 32'(irq_o), 32'h0);

      // R2 enable write sweep with junk in upper bits
      for (int v = 0; v < 256; v++) begin
         wr(A_EN, {24'hABCDEF, 8'(v)});
         rd(A_EN, d);
         check("R2 enable readback", d, 32'(v));
      end

      // R3 set / clear enable
      for (int v = 0; v < 64; v++) begin
         logic [7:0] m, c, e;
         m = 8'(v * 29); c = 8'(v * 53 + 7);
         wr(A_EN, 32'(v));
         wr(A_SET, {24'hFFFFFF, m});
         e = 8'(v) | m;
         rd(A_EN, d);
         check("R3 set-enable", d, 32'(e));
         wr(A_CLR, 32'(c));
         rd(A_EN, d);
         check("R3 clear-enable", d, 32'(e & ~c));
      end

      // R9 / R10 control gating
      wr(A_EN, 32'hFF);
      pulse(8'h01);
      check("R9 no gates", 32'(irq_o), 32'h0);
      wr(A_CTRL, 32'h1);
      rd(A_CTRL, d);
      check("R9 run only readback", d, 32'h1);
      check("R9 run only irq", 32'(irq_o), 32'h0);
      wr(A_CTRL, 32'h2);
      rd(A_CTRL, d);
      check("R9 hw only readback", d, 32'h2);
      check("R9 hw only irq", 32'(irq_o), 32'h0);
      wr(A_CTRL, 32'h0);
      rd(A_CTRL, d);
      check("R10 hw bit sticky", d, 32'h2);
      wr(A_CTRL, 32'h3);
      check("R9 both gates irq", 32'(irq_o), 32'h1);
      wr(A_ACK, 32'hFFFF_FFFF);
      check("R9 irq after ack", 32'(irq_o), 32'h0);

      // R7 / R8 / R9 full status sweep
      for (int p = 0; p < 256; p++) begin
         logic [7:0] e, pe;
         e = 8'(p * 37 + 11);
         pe = 8'(p) & e;
         wr(A_EN, 32'(e));
         pulse(8'(p));
         rd(A_STAT, d);
         check("R4 R5 status capture", d, 32'(p));
         rd(A_PEND, d);
         check("R7 pending", d, 32'(pe));
         rd(A_VEC, d);
         check("R8 vector", d, lowest(pe));
         check("R9 request", 32'(irq_o), 32'(|pe));
         wr(A_ACK, 32'hFF);
         rd(A_STAT, d);
         check("R6 ack all", d, 32'h0);
      end

      // R6 partial acknowledge
      pulse(8'hFF);
      wr(A_ACK, 32'h0F);
      rd(A_STAT, d);
      check("R6 partial ack", d, 32'hF0);
      wr(A_ACK, 32'hFF);

      // R4 edge line held high
      @(negedge clk); src_i[5] = 1'b1;
      repeat (3) @(negedge clk);
      rd(A_STAT, d);
      check("R4 edge set", d, 32'h20);
      wr(A_ACK, 32'h20);
      repeat (2) @(negedge clk);
      rd(A_STAT, d);
      check("R4 held edge no reset", d, 32'h0);
      src_i[5] = 1'b0;
      @(negedge clk); src_i[5] = 1'b1;
      @(negedge clk);
      rd(A_STAT, d);
      check("R4 second edge", d, 32'h20);
      src_i[5] = 1'b0;
      wr(A_ACK, 32'h20);

      // R5 level line held high across acknowledge
      @(negedge clk); src_i[2] = 1'b1;
      wr(A_ACK, 32'h04);
      rd(A_STAT, d);
      check("R5 level reasserts", d, 32'h04);
      src_i[2] = 1'b0;
      wr(A_ACK, 32'h04);
      rd(A_STAT, d);
      check("R5 level cleared", d, 32'h0);

      // R6 acknowledge collides with new edge
      @(negedge clk);
      src_i[6] = 1'b1; reg_addr = A_ACK; reg_wr = 1'b1; reg_wdata = 32'h40;
      @(negedge clk);
      reg_wr = 1'b0;
      rd(A_STAT, d);
      check("R6 event beats ack", d, 32'h40);
      src_i[6] = 1'b0;

      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule